// File: doc/BRIEF.md
# Sprite Table Copy Engine

This block moves a fixed run of bytes from a 256-byte page of system memory into the sprite attribute table. Software starts a copy by writing a page number to a control address. The block then owns the system memory bus. It reads one source byte and writes it to the next table slot once every four machine-cycle ticks, until 160 bytes have been moved.

The block sits between the CPU and the system memory bus. While no copy runs, CPU accesses pass straight through to memory, with read data returned one clock after the read strobe. The small high RAM at the top of the map lives inside the block and is always served locally. While a copy runs, the CPU can reach only that high RAM. Every other CPU read returns 0xFF, and every other CPU write is discarded. The one exception is the control address, which restarts the copy.

Top module: `sprite_dma_ctrl`

## Requirements
- R1: A CPU write of page P to the control address 0xFF46 with P <= 0xF1 sets busy from the next clock. The copy then reads source addresses P*256 upward.
- R2: A control write with P > 0xF1 is ignored. busy stays low and the system bus sees no write.
- R3: A copy moves exactly 160 bytes. Source byte P*256+i lands at 0xFE00+i for i = 0..159.
- R4: A byte step begins on the clock after the 4th counted tick following the trigger, and after every 4th counted tick after that. A step is one read clock (bus address = source, no write strobe) followed by one write clock (bus address = destination, write strobe high). A tick in the trigger clock is not counted.
- R5: Pacing advances only on clocks where tick is high. With tick held low, no step starts and busy holds.
- R6: While busy, a CPU read outside 0xFF80..0xFFFE returns 0xFF on cpu_rdata in the clock after the read strobe.
- R7: While busy, CPU writes outside 0xFF80..0xFFFE never reach the system bus, and the target memory is unchanged.
- R8: High RAM at 0xFF80..0xFFFE is read and written locally at all times, with read data one clock after the strobe. A high RAM access never drives a write onto the system bus.
- R9: busy falls at the clock edge that ends the 160th write clock. From that clock on, CPU accesses pass through again.
- R10: A valid control write during a copy restarts it with the new source page, destination 0xFE00, count 160 and the pacing count cleared.
- R11: Reset clears busy, cancels any copy in progress and sets cpu_rdata to 0x00.
- R12: While idle, cpu_addr, cpu_wdata and cpu_we appear on the system bus in the same clock, except for high RAM and the control address. A CPU read returns mem_rdata on cpu_rdata in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Machine-cycle enable used for pacing |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe |
| cpu_re | input | 1 | CPU read strobe |
| cpu_rdata | output | 8 | CPU read data, valid the clock after cpu_re |
| mem_addr | output | 16 | System bus address |
| mem_rdata | input | 8 | System bus read data, combinational from mem_addr |
| mem_wdata | output | 8 | System bus write data |
| mem_we | output | 1 | System bus write strobe |
| busy | output | 1 | Copy in progress |

## Verification
If the pacing count or step phase goes wrong, mem_we and mem_addr drift from the expected schedule within four ticks. The per-clock comparison against the bench model flags this on the first clock where they disagree. If the source or destination address is corrupted, the wrong byte lands in the table, and the bench reports it at the end of the copy. If the count is wrong, busy stays high too long or falls too early, and this shows up as a length mismatch at the falling edge of busy. If the access gate is faulty, the CPU sees something other than 0xFF on the clock after a blocked read, or memory content changes that should have stayed fixed.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  typedef enum logic [1:0] {
    PH_WAIT  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } phase_t;
endpackage

// File: rtl/sdma_pacer.sv
module sdma_pacer #(
  parameter int PACE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic restart,
  input  logic active,
  output logic step
);
  localparam int CW = (PACE > 1) ? $clog2(PACE) : 1;
  localparam logic [CW-1:0] LAST = CW'(PACE - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (active && tick) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign step = active && tick && !restart && (cnt == LAST);

  assert_hold_without_tick_R5: assert property (@(posedge clk) disable iff (rst)
    (!tick && !restart) |=> $stable(cnt));
endmodule

// File: rtl/sdma_seq.sv
module sdma_seq
  import sdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int XFER_LEN = 160,
  parameter logic [ADDR_W-1:0] TABLE_BASE = 16'hFE00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig,
  input  logic [DATA_W-1:0] page,
  input  logic              step,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic [ADDR_W-1:0] seq_addr,
  output logic [DATA_W-1:0] seq_wdata,
  output logic              seq_we
);
  localparam int RW = $clog2(XFER_LEN + 1);
  localparam logic [RW-1:0] LEN = RW'(XFER_LEN);
  localparam logic [ADDR_W:0] DST_END = {1'b0, TABLE_BASE} + (ADDR_W+1)'(XFER_LEN);

  phase_t            phase;
  logic [ADDR_W-1:0] src, dst;
  logic [RW-1:0]     rem;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      phase  <= PH_WAIT;
      src    <= '0;
      dst    <= '0;
      rem    <= '0;
      data_q <= '0;
    end else if (trig) begin
      busy  <= 1'b1;
      phase <= PH_WAIT;
      src   <= {page, {(ADDR_W-DATA_W){1'b0}}};
      dst   <= TABLE_BASE;
      rem   <= LEN;
    end else if (busy) begin
      unique case (phase)
        PH_WAIT:  if (step) phase <= PH_READ;
        PH_READ: begin
          data_q <= mem_rdata;
          phase  <= PH_WRITE;
        end
        PH_WRITE: begin
          src   <= src + 1'b1;
          dst   <= dst + 1'b1;
          rem   <= rem - 1'b1;
          phase <= PH_WAIT;
          if (rem == RW'(1)) busy <= 1'b0;
        end
        default: phase <= PH_WAIT;
      endcase
    end
  end

  assign seq_we    = busy && (phase == PH_WRITE);
  assign seq_addr  = (phase == PH_WRITE) ? dst : src;
  assign seq_wdata = data_q;

  assert_dst_in_table_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> ({1'b0, dst} >= {1'b0, TABLE_BASE} && {1'b0, dst} < DST_END));
  assert_read_then_write_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && phase == PH_READ && !trig) |=> (busy && phase == PH_WRITE));
  assert_done_after_last_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && phase == PH_WRITE && rem == RW'(1) && !trig) |=> !busy);
  assert_count_reload_R10: assert property (@(posedge clk) disable iff (rst)
    trig |=> (busy && rem == LEN && dst == TABLE_BASE));
endmodule

// File: rtl/sdma_cpu_gate.sv
module sdma_cpu_gate #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] HRAM_LO = 16'hFF80,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'hFF46,
  parameter logic [DATA_W-1:0] MAX_PAGE = 8'hF1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_we,
  input  logic              cpu_re,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              busy,
  input  logic [ADDR_W-1:0] seq_addr,
  input  logic [DATA_W-1:0] seq_wdata,
  input  logic              seq_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              trig
);
  localparam int HRAM_SPAN = (1 << ADDR_W) - int'(HRAM_LO);
  localparam int HRAM_AW = $clog2(HRAM_SPAN);

  logic [DATA_W-1:0] hram [HRAM_SPAN];
  logic [DATA_W-1:0] hram_q, bus_q;
  logic              sel_hram;
  logic              is_hram, is_ctrl;
  logic [HRAM_AW-1:0] hidx;

  assign is_hram = (cpu_addr >= HRAM_LO) && (cpu_addr != {ADDR_W{1'b1}});
  assign is_ctrl = (cpu_addr == CTRL_ADDR);
  assign hidx    = cpu_addr[HRAM_AW-1:0];
  assign trig    = cpu_we && is_ctrl && (cpu_wdata <= MAX_PAGE);

  always_ff @(posedge clk) begin
    if (cpu_we && is_hram) hram[hidx] <= cpu_wdata;
    if (cpu_re && is_hram) hram_q <= hram[hidx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_hram <= 1'b0;
      bus_q    <= '0;
    end else if (cpu_re) begin
      sel_hram <= is_hram;
      if (!is_hram) bus_q <= busy ? {DATA_W{1'b1}} : mem_rdata;
    end
  end

  assign cpu_rdata = sel_hram ? hram_q : bus_q;

  always_comb begin
    if (busy) begin
      mem_addr  = seq_addr;
      mem_wdata = seq_wdata;
      mem_we    = seq_we;
    end else begin
      mem_addr  = cpu_addr;
      mem_wdata = cpu_wdata;
      mem_we    = cpu_we && !is_hram && !is_ctrl;
    end
  end

  assert_blocked_read_ff_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && cpu_re && !is_hram) |=> (cpu_rdata == {DATA_W{1'b1}}));
  assert_cpu_write_dropped_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && !seq_we) |-> !mem_we);
  assert_hram_stays_local_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && cpu_we && is_hram) |-> !mem_we);
  assert_idle_read_pass_R12: assert property (@(posedge clk) disable iff (rst)
    (!busy && cpu_re && !is_hram) |=> (cpu_rdata == $past(mem_rdata)));
endmodule

// File: rtl/sprite_dma_ctrl.sv
module sprite_dma_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int XFER_LEN = 160,
  parameter int PACE = 4,
  parameter logic [ADDR_W-1:0] TABLE_BASE = 16'hFE00,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'hFF46,
  parameter logic [ADDR_W-1:0] HRAM_LO = 16'hFF80,
  parameter logic [DATA_W-1:0] MAX_PAGE = 8'hF1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_we,
  input  logic              cpu_re,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              busy
);
  logic              trig, step, seq_we;
  logic [ADDR_W-1:0] seq_addr;
  logic [DATA_W-1:0] seq_wdata;

  sdma_cpu_gate #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HRAM_LO(HRAM_LO),
    .CTRL_ADDR(CTRL_ADDR), .MAX_PAGE(MAX_PAGE)
  ) u_gate (
    .clk(clk), .rst(rst),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we),
    .cpu_re(cpu_re), .cpu_rdata(cpu_rdata),
    .busy(busy), .seq_addr(seq_addr), .seq_wdata(seq_wdata), .seq_we(seq_we),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .trig(trig)
  );

  sdma_pacer #(.PACE(PACE)) u_pacer (
    .clk(clk), .rst(rst), .tick(tick), .restart(trig), .active(busy), .step(step)
  );

  sdma_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .XFER_LEN(XFER_LEN), .TABLE_BASE(TABLE_BASE)
  ) u_seq (
    .clk(clk), .rst(rst), .trig(trig), .page(cpu_wdata), .step(step),
    .mem_rdata(mem_rdata), .busy(busy), .seq_addr(seq_addr),
    .seq_wdata(seq_wdata), .seq_we(seq_we)
  );

  assert_trigger_starts_R1: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && cpu_addr == CTRL_ADDR && cpu_wdata <= MAX_PAGE) |=> busy);
  assert_bad_page_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && cpu_we && cpu_addr == CTRL_ADDR && cpu_wdata > MAX_PAGE) |=> !busy);
  assert_reset_clears_R11: assert property (@(posedge clk)
    rst |=> !busy);
endmodule

// File: tb/sprite_dma_ctrl_test.sv
`timescale 1ns/100ps
module sprite_dma_ctrl_test;
  logic clk = 1'b0, rst = 1'b1, tick = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_we = 1'b0, cpu_re = 1'b0;
  logic [7:0]  cpu_rdata, mem_wdata, mem_rdata;
  logic [15:0] mem_addr;
  logic        mem_we, busy;

  logic [7:0] mem [65536];
  logic [7:0] m_hram [128];
  int checks = 0, errors = 0, cyc = 0;
  int tick_mode = 0, tdiv = 0;
  int busy_cnt = 0, we_cnt = 0;
  bit started = 0;

  // reference model state
  bit m_busy; int m_cnt, m_ph, m_rem;
  logic [15:0] m_src, m_dst; logic [7:0] m_byte, m_rd;

  always #2.5 clk = ~clk;

  sprite_dma_ctrl uut (
    .clk(clk), .rst(rst), .tick(tick), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .cpu_re(cpu_re), .cpu_rdata(cpu_rdata), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .mem_we(mem_we), .busy(busy)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  function automatic bit hr(input logic [15:0] a);
    return (a >= 16'hFF80) && (a != 16'hFFFF);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit trg, stp;
    started = 1;
    if (rst) begin
      m_busy = 0; m_cnt = 0; m_ph = 0; m_rem = 0; m_rd = 8'h00;
    end else begin
      if (cpu_re) m_rd = hr(cpu_addr) ? m_hram[cpu_addr[6:0]] : (m_busy ? 8'hFF : mem[cpu_addr]);
      if (cpu_we && hr(cpu_addr)) m_hram[cpu_addr[6:0]] = cpu_wdata;
      trg = cpu_we && cpu_addr == 16'hFF46 && cpu_wdata <= 8'hF1;
      stp = m_busy && tick && m_cnt == 3;
      if (trg) begin
        m_busy = 1; m_cnt = 0; m_ph = 0; m_src = {cpu_wdata, 8'h00}; m_dst = 16'hFE00; m_rem = 160;
      end else if (m_busy) begin
        if (m_ph == 0) begin if (stp) m_ph = 1; end
        else if (m_ph == 1) begin m_byte = mem[m_src]; m_ph = 2; end
        else begin
          m_src++; m_dst++; m_rem--; m_ph = 0;
          if (m_rem == 0) m_busy = 0;
        end
        if (tick) m_cnt = (m_cnt + 1) % 4;
      end
    end
  end

  always @(negedge clk) if (started) begin
    logic ew; logic [15:0] ea;
    ew = m_busy ? (m_ph == 2) : (cpu_we && !hr(cpu_addr) && cpu_addr != 16'hFF46);
    ea = m_busy ? ((m_ph == 2) ? m_dst : m_src) : cpu_addr;
    chk("R9", "busy", busy, m_busy);
    chk("R4", "mem_we", mem_we, ew);
    chk("R4", "mem_addr", mem_addr, ea);
    if (ew) chk("R3", "mem_wdata", mem_wdata, m_busy ? m_byte : cpu_wdata);
    chk("R6", "cpu_rdata", cpu_rdata, m_rd);
    if (busy) busy_cnt++;
    if (mem_we) we_cnt++;
  end

  always @(negedge clk) begin
    #1;
    tdiv = (tdiv + 1) % 3;
    tick = (tick_mode == 1) ? 1'b1 : (tick_mode == 3) ? (tdiv == 0) : 1'b0;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(negedge clk); #1;
    cpu_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); #1;
    cpu_addr = a; cpu_re = 1'b1;
    @(negedge clk); #1;
    cpu_re = 1'b0; d = cpu_rdata;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    #1;
  endtask

  initial begin
    logic [7:0] v;
    int bad;
    for (int i = 0; i < 65536; i++) mem[i] = 8'h00;
    for (int i = 0; i < 160; i++) begin
      mem[16'hC000 + i] = 8'(i * 7 + 3);
      mem[16'hF100 + i] = 8'(i ^ 8'hA5);
    end
    idle(3);
    rst = 1'b0;
    idle(1);
    chk("R11", "busy after reset", busy, 0);
    chk("R11", "cpu_rdata after reset", cpu_rdata, 8'h00);

    // R12 pass-through
    wr(16'hC100, 8'h3C);
    idle(1);
    chk("R12", "idle write reached memory", mem[16'hC100], 8'h3C);
    rd(16'hC005, v);
    chk("R12", "idle read data", v, mem[16'hC005]);

    // R8 high RAM idle
    wr(16'hFF90, 8'h5A);
    rd(16'hFF90, v);
    chk("R8", "hram readback", v, 8'h5A);
    chk("R8", "hram not on bus", mem[16'hFF90], 8'h00);

    // R2 rejected page
    wr(16'hFF46, 8'hF2);
    idle(10);
    chk("R2", "busy after page F2", busy, 0);

    // R1/R3/R4/R6/R7/R8 main copy, tick every clock
    tick_mode = 1;
    busy_cnt = 0;
    wr(16'hFF46, 8'hC0);
    chk("R1", "busy after trigger", busy, 1);
    rd(16'hC000, v);
    chk("R6", "blocked read", v, 8'hFF);
    wr(16'hD000, 8'h77);
    wr(16'hFF91, 8'h66);
    rd(16'hFF91, v);
    chk("R8", "hram during copy", v, 8'h66);
    rd(16'hFFFF, v);
    chk("R6", "blocked read FFFF", v, 8'hFF);
    wait_idle();
    chk("R4", "busy length in clocks", busy_cnt, 642);
    chk("R7", "dropped write", mem[16'hD000], 8'h00);
    bad = 0;
    for (int i = 0; i < 160; i++) if (mem[16'hFE00 + i] !== mem[16'hC000 + i]) bad++;
    chk("R3", "table mismatches for page C0", bad, 0);
    chk("R3", "byte past table untouched", mem[16'hFEA0], 8'h00);

    // R9 pass-through right after completion
    wr(16'hC101, 8'h99);
    idle(1);
    chk("R9", "write right after copy", mem[16'hC101], 8'h99);

    // R1 boundary page F1
    wr(16'hFF46, 8'hF1);
    chk("R1", "busy for page F1", busy, 1);
    wait_idle();
    chk("R1", "first byte from F100", mem[16'hFE00], mem[16'hF100]);
    chk("R1", "last byte from F19F", mem[16'hFE9F], mem[16'hF19F]);

    // R10 restart, R5 tick pause
    for (int i = 0; i < 160; i++) mem[16'hD000 + i] = 8'(8'hE1 - i);
    tick_mode = 3;
    wr(16'hFF46, 8'hC0);
    idle(40);
    wr(16'hFF46, 8'hD0);
    idle(25);
    tick_mode = 0;
    idle(4);
    we_cnt = 0;
    idle(30);
    chk("R5", "writes while ticks held low", we_cnt, 0);
    chk("R5", "busy holds without ticks", busy, 1);
    tick_mode = 3;
    wait_idle();
    bad = 0;
    for (int i = 0; i < 160; i++) if (mem[16'hFE00 + i] !== mem[16'hD000 + i]) bad++;
    chk("R10", "table mismatches after restart", bad, 0);

    // R11 reset mid-copy
    tick_mode = 1;
    wr(16'hFF46, 8'hC0);
    idle(20);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(1);
    chk("R11", "busy after mid-copy reset", busy, 0);
    wr(16'hC102, 8'h12);
    idle(1);
    chk("R11", "pass-through after reset", mem[16'hC102], 8'h12);

    idle(5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule